// File: doc/BRIEF.md
# Single-Event-Upset Campaign Sequencer

This block runs a fault-injection campaign against a small processor core. Two instances of the same core sit next to it: a golden copy that is never disturbed, and a device under test that receives the upsets. The sequencer holds both cores in reset between runs and drives the reset of both. At the start of a campaign it makes one calibration run with no upset, in which it measures how many cycles the golden program needs. Every later run gets exactly one bit-flip. A pseudo-random generator picks the clock cycle and the bit for that flip, and the flip always lands in the register group selected for the campaign.

While a run is in progress the sequencer compares the output strobes and data of the two cores. It also watches for the end-of-program flag from the device under test. At the end of the run it puts the run into one of three outcome classes and adds one to the saturating counter of that class:
- correct: the program finished and every output matched the golden copy;
- silent corruption: the program finished, but at least one output differed from the golden copy;
- hang: the program never finished.

After the programmed number of injection runs the sequencer raises a done flag and keeps the totals until the next start.

Top module: `seu_campaign_ctrl`

## Requirements
- R1: The random source is a 16-bit Galois LFSR. One step is: shift right by one; if the bit shifted out was 1, XOR the result with 0xB400. A seed of 0 is replaced by 1. Each injection run takes the current state `a` and then steps the LFSR twice; the state after the first step is `b`. The flip takes place in the run cycle `a mod G`. G is the golden length, and run cycle 0 is the first cycle in which the core reset is low.
- R2: `flip_set` gives the attacked group: 0 register file, 1 program counter, 2 flags, 3 stack pointer, 4 pipeline. A `tgt_sel` value above 4 selects group 0. `flip_idx` equals `b mod` the bit width of that group. The default widths are 64, 10, 2, 5 and 24 bits.
- R3: Each injection run has exactly one `flip_stb` pulse, and the calibration run has none. A campaign of N runs therefore gives N pulses.
- R4: A run in which `dut_done` rises and no output mismatch has been seen adds one to `cnt_unace`.
- R5: A run in which `dut_done` rises after, or in the same cycle as, at least one mismatch adds one to `cnt_sdc`. A mismatch is a cycle in which either core strobes an output and the strobes or the data differ.
- R6: A run in which `dut_done` has not risen after 2·G run cycles adds one to `cnt_hang`. This holds even when a mismatch was seen earlier in the run.
- R7: All three counters saturate at their maximum value and never wrap.
- R8: `start` is accepted only while the sequencer is idle or finished. It clears the three counters. `camp_done` rises after `run_count` injection runs, or directly after calibration when `run_count` is 0, and while it is high the counters do not change.
- R9: During reset the outputs are: `core_rst` 1, `flip_stb` 0, `camp_done` 0 and all counters 0.
- R10: The calibration run sets G to the number of cycles from the release of the core reset to `gold_done`, with a minimum of 1. `core_rst` is high between runs and is never high in the same cycle as a flip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a campaign |
| run_count | input | 16 | Number of injection runs |
| seed | input | 16 | LFSR seed |
| tgt_sel | input | 3 | Register group to attack |
| gold_done | input | 1 | Golden core finished its program |
| gold_out_vld | input | 1 | Golden core output strobe |
| gold_out_data | input | 8 | Golden core output data |
| dut_done | input | 1 | Device under test finished its program |
| dut_out_vld | input | 1 | Device under test output strobe |
| dut_out_data | input | 8 | Device under test output data |
| core_rst | output | 1 | Reset to both cores |
| flip_stb | output | 1 | Bit-flip strobe into the device under test |
| flip_set | output | 3 | Group that contains the flipped bit |
| flip_idx | output | 6 | Bit index within that group |
| cnt_unace | output | 16 | Correct-outcome total |
| cnt_sdc | output | 16 | Silent-corruption total |
| cnt_hang | output | 16 | Hang total |
| camp_done | output | 1 | Campaign finished |

## Verification
The bench builds the block with 3-bit outcome counters, so a ten-run campaign drives the correct-outcome total into saturation within a few hundred cycles. All other parameters keep their defaults. A behavioural core model with a 20-cycle golden program sets the watchdog limit to 40 cycles. In that model, the attacked group decides the outcome: flag and stack pointer flips cause no harm, register file flips corrupt the final output, program counter flips stop the program from finishing, and pipeline flips do both. Every outcome class, the mismatch-then-hang ordering, a zero seed, an out-of-range group select and a zero-length campaign can therefore each be reached on purpose.

// File: rtl/seu_campaign_pkg.sv
package seu_campaign_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CALRST, ST_CAL, ST_PREP, ST_RUN, ST_FIN
  } fsm_e;

  typedef enum logic [1:0] {
    CLS_UNACE = 2'd0,
    CLS_SDC   = 2'd1,
    CLS_HANG  = 2'd2
  } cls_e;

  localparam int N_CLS = 3;

  localparam logic [2:0] SET_RF   = 3'd0;
  localparam logic [2:0] SET_PC   = 3'd1;
  localparam logic [2:0] SET_FLG  = 3'd2;
  localparam logic [2:0] SET_SP   = 3'd3;
  localparam logic [2:0] SET_PIPE = 3'd4;
endpackage

// File: rtl/seu_lfsr16.sv
module seu_lfsr16 #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         adv,
  output logic [W-1:0] state,
  output logic [W-1:0] step1
);
  logic [W-1:0] st_q, st_d, step2;

  function automatic logic [W-1:0] nxt(logic [W-1:0] s);
    return (s >> 1) ^ (s[0] ? TAPS : '0);
  endfunction

  assign step1 = nxt(st_q);
  assign step2 = nxt(step1);

  always_comb begin
    st_d = st_q;
    if (load)     st_d = (seed == '0) ? W'(1) : seed;
    else if (adv) st_d = step2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           st_q <= W'(1);
    else if (load || adv) st_q <= st_d;
  end

  assign state = st_q;
endmodule

// File: rtl/seu_mod_unit.sv
module seu_mod_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  sh_q, rem_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;
  logic [W:0]    trial, diff;
  logic          ge;

  assign trial = {rem_q, sh_q[W-1]};
  assign diff  = trial - {1'b0, den};
  assign ge    = trial >= {1'b0, den};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start) begin
      sh_q   <= num;
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      sh_q   <= sh_q << 1;
      rem_q  <= ge ? diff[W-1:0] : trial[W-1:0];
      cnt_q  <= cnt_q + 1'b1;
      busy_q <= (cnt_q != CW'(W - 1));
      done_q <= (cnt_q == CW'(W - 1));
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done = done_q;
  assign rem  = rem_q;
endmodule

// File: rtl/seu_sat_cnt.sv
module seu_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  logic [W-1:0] q_q;
  logic         en;

  assign en = clr || (inc && (q_q != '1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_q <= '0;
    else if (en) q_q <= clr ? '0 : q_q + 1'b1;
  end

  assign q = q_q;
endmodule

// File: rtl/seu_campaign_ctrl.sv
module seu_campaign_ctrl
  import seu_campaign_pkg::*;
#(
  parameter int  LW     = 16,
  parameter int  CNT_W  = 16,
  parameter int  DATA_W = 8,
  parameter int  RUNS_W = 16,
  parameter int  W_RF   = 64,
  parameter int  W_PC   = 10,
  parameter int  W_FLG  = 2,
  parameter int  W_SP   = 5,
  parameter int  W_PIPE = 24,
  localparam int W_MAX  = (W_RF > W_PC ? W_RF : W_PC) > (W_FLG > W_SP ? (W_FLG > W_PIPE ? W_FLG : W_PIPE) : (W_SP > W_PIPE ? W_SP : W_PIPE))
                          ? (W_RF > W_PC ? W_RF : W_PC)
                          : (W_FLG > W_SP ? (W_FLG > W_PIPE ? W_FLG : W_PIPE) : (W_SP > W_PIPE ? W_SP : W_PIPE)),
  localparam int IDX_W  = (W_MAX > 1) ? $clog2(W_MAX) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [RUNS_W-1:0] run_count,
  input  logic [LW-1:0]     seed,
  input  logic [2:0]        tgt_sel,
  input  logic              gold_done,
  input  logic              gold_out_vld,
  input  logic [DATA_W-1:0] gold_out_data,
  input  logic              dut_done,
  input  logic              dut_out_vld,
  input  logic [DATA_W-1:0] dut_out_data,
  output logic              core_rst,
  output logic              flip_stb,
  output logic [2:0]        flip_set,
  output logic [IDX_W-1:0]  flip_idx,
  output logic [CNT_W-1:0]  cnt_unace,
  output logic [CNT_W-1:0]  cnt_sdc,
  output logic [CNT_W-1:0]  cnt_hang,
  output logic              camp_done
);
  // Reset: asserted asynchronously, released through two flops
  logic [1:0] rsync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  fsm_e              st_q, st_d;
  logic [LW:0]       cyc_q, cyc_d;
  logic [LW-1:0]     glen_q, glen_d, inj_q, inj_d;
  logic [RUNS_W-1:0] runs_q, runs_d;
  logic [2:0]        sel_q, sel_d;
  logic [IDX_W-1:0]  bidx_q, bidx_d;
  logic              pend_q, pend_d, flipped_q, flipped_d;

  logic              evt_vld, div_start, lfsr_adv, lfsr_load, cnt_clr;
  cls_e              evt_cls;
  logic [LW-1:0]     rnd_a, rnd_b, div_rem;
  logic              div_done, mism;
  logic [LW:0]       wd_lim;

  function automatic logic [IDX_W-1:0] idx_of(logic [2:0] s, logic [LW-1:0] v);
    case (s)
      SET_PC:   return IDX_W'(v % LW'(W_PC));
      SET_FLG:  return IDX_W'(v % LW'(W_FLG));
      SET_SP:   return IDX_W'(v % LW'(W_SP));
      SET_PIPE: return IDX_W'(v % LW'(W_PIPE));
      default:  return IDX_W'(v % LW'(W_RF));
    endcase
  endfunction

  seu_lfsr16 #(.W(LW)) u_lfsr (
    .clk(clk), .rst_n(rst_ni), .load(lfsr_load), .seed(seed),
    .adv(lfsr_adv), .state(rnd_a), .step1(rnd_b)
  );

  seu_mod_unit #(.W(LW)) u_mod (
    .clk(clk), .rst_n(rst_ni), .start(div_start), .num(rnd_a),
    .den(glen_q), .done(div_done), .rem(div_rem)
  );

  logic [CNT_W-1:0] cnt_q [N_CLS];
  for (genvar k = 0; k < N_CLS; k++) begin : g_cnt
    seu_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_ni), .clr(cnt_clr),
      .inc(evt_vld && (evt_cls == cls_e'(k))), .q(cnt_q[k])
    );
  end

  assign mism   = (gold_out_vld || dut_out_vld) &&
                  ((gold_out_vld != dut_out_vld) || (gold_out_data != dut_out_data));
  assign wd_lim = {glen_q, 1'b0};

  always_comb begin
    st_d      = st_q;
    cyc_d     = cyc_q;
    glen_d    = glen_q;
    inj_d     = inj_q;
    runs_d    = runs_q;
    sel_d     = sel_q;
    bidx_d    = bidx_q;
    pend_d    = pend_q;
    flipped_d = flipped_q;
    evt_vld   = 1'b0;
    evt_cls   = CLS_UNACE;
    div_start = 1'b0;
    lfsr_adv  = 1'b0;
    lfsr_load = 1'b0;
    cnt_clr   = 1'b0;
    case (st_q)
      ST_IDLE, ST_FIN: begin
        if (start) begin
          st_d      = ST_CALRST;
          runs_d    = run_count;
          sel_d     = (tgt_sel > SET_PIPE) ? SET_RF : tgt_sel;
          lfsr_load = 1'b1;
          cnt_clr   = 1'b1;
        end
      end
      ST_CALRST: begin
        st_d  = ST_CAL;
        cyc_d = '0;
      end
      ST_CAL: begin
        cyc_d = cyc_q + 1'b1;
        if (gold_done) begin
          glen_d = (cyc_q[LW-1:0] == '0) ? LW'(1) : cyc_q[LW-1:0];
          if (runs_q == '0) begin
            st_d = ST_FIN;
          end else begin
            st_d      = ST_PREP;
            div_start = 1'b1;
            lfsr_adv  = 1'b1;
            bidx_d    = idx_of(sel_q, rnd_b);
          end
        end
      end
      ST_PREP: begin
        if (div_done) begin
          st_d      = ST_RUN;
          inj_d     = div_rem;
          cyc_d     = '0;
          pend_d    = 1'b0;
          flipped_d = 1'b0;
        end
      end
      ST_RUN: begin
        cyc_d  = cyc_q + 1'b1;
        pend_d = pend_q || mism;
        if (cyc_q == {1'b0, inj_q}) flipped_d = 1'b1;
        if (dut_done || (cyc_q >= wd_lim)) begin
          evt_vld = 1'b1;
          if (!dut_done)            evt_cls = CLS_HANG;
          else if (pend_q || mism)  evt_cls = CLS_SDC;
          else                      evt_cls = CLS_UNACE;
          runs_d = runs_q - 1'b1;
          if (runs_q == RUNS_W'(1)) begin
            st_d = ST_FIN;
          end else begin
            st_d      = ST_PREP;
            div_start = 1'b1;
            lfsr_adv  = 1'b1;
            bidx_d    = idx_of(sel_q, rnd_b);
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cyc_q     <= '0;
      glen_q    <= LW'(1);
      inj_q     <= '0;
      runs_q    <= '0;
      sel_q     <= SET_RF;
      bidx_q    <= '0;
      pend_q    <= 1'b0;
      flipped_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      cyc_q     <= cyc_d;
      glen_q    <= glen_d;
      inj_q     <= inj_d;
      runs_q    <= runs_d;
      sel_q     <= sel_d;
      bidx_q    <= bidx_d;
      pend_q    <= pend_d;
      flipped_q <= flipped_d;
    end
  end

  assign core_rst  = (st_q != ST_CAL) && (st_q != ST_RUN);
  assign flip_stb  = (st_q == ST_RUN) && !flipped_q && (cyc_q == {1'b0, inj_q});
  assign flip_set  = sel_q;
  assign flip_idx  = bidx_q;
  assign camp_done = (st_q == ST_FIN);
  assign cnt_unace = cnt_q[CLS_UNACE];
  assign cnt_sdc   = cnt_q[CLS_SDC];
  assign cnt_hang  = cnt_q[CLS_HANG];
endmodule

// File: rtl/seu_campaign_chk.sv
module seu_campaign_chk #(
  parameter int CNT_W  = 16,
  parameter int IDX_W  = 6,
  parameter int W_RF   = 64,
  parameter int W_PC   = 10,
  parameter int W_FLG  = 2,
  parameter int W_SP   = 5,
  parameter int W_PIPE = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             core_rst,
  input logic             flip_stb,
  input logic [2:0]       flip_set,
  input logic [IDX_W-1:0] flip_idx,
  input logic [CNT_W-1:0] cnt_unace,
  input logic [CNT_W-1:0] cnt_sdc,
  input logic [CNT_W-1:0] cnt_hang,
  input logic             camp_done
);
  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seen_q <= 1'b0;
    else if (core_rst) seen_q <= 1'b0;
    else if (flip_stb) seen_q <= 1'b1;
  end

  function automatic int grp_w(logic [2:0] s);
    case (s)
      3'd1:    return W_PC;
      3'd2:    return W_FLG;
      3'd3:    return W_SP;
      3'd4:    return W_PIPE;
      default: return W_RF;
    endcase
  endfunction

  // R3
  one_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flip_stb |-> !seen_q);

  // R2
  flip_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flip_stb |-> (int'(flip_idx) < grp_w(flip_set)));

  // R10
  flip_out_of_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flip_stb |-> !core_rst);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (camp_done && !start) |=> $stable({cnt_unace, cnt_sdc, cnt_hang}));

  // R7
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_unace == '1) && !start) |=> (cnt_unace == '1));

  // R6
  one_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($countones({cnt_unace != $past(cnt_unace),
                             cnt_sdc   != $past(cnt_sdc),
                             cnt_hang  != $past(cnt_hang)}) <= 1));
endmodule

bind seu_campaign_ctrl seu_campaign_chk #(
  .CNT_W(CNT_W), .IDX_W(IDX_W), .W_RF(W_RF), .W_PC(W_PC),
  .W_FLG(W_FLG), .W_SP(W_SP), .W_PIPE(W_PIPE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .core_rst(core_rst),
  .flip_stb(flip_stb), .flip_set(flip_set), .flip_idx(flip_idx),
  .cnt_unace(cnt_unace), .cnt_sdc(cnt_sdc), .cnt_hang(cnt_hang),
  .camp_done(camp_done)
);

// File: tb/seu_campaign_ctrl_bench.sv
module seu_campaign_ctrl_bench;
  localparam int L  = 20;
  localparam int CW = 3;

  typedef struct packed {
    logic [2:0]  sel;
    logic [7:0]  runs;
    logic [15:0] seed;
    logic [7:0]  eu;
    logic [7:0]  es;
    logic [7:0]  eh;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{3'd0, 8'd3, 16'hACE1, 8'd0, 8'd3, 8'd0},
    '{3'd1, 8'd2, 16'h1234, 8'd0, 8'd0, 8'd2},
    '{3'd2, 8'd4, 16'h0001, 8'd4, 8'd0, 8'd0},
    '{3'd3, 8'd3, 16'h0000, 8'd3, 8'd0, 8'd0},
    '{3'd4, 8'd2, 16'hBEEF, 8'd0, 8'd0, 8'd2},
    '{3'd6, 8'd2, 16'h5555, 8'd0, 8'd2, 8'd0}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, start;
  logic [15:0] run_count, seed;
  logic [2:0]  tgt_sel;
  logic        gold_done, gold_out_vld, dut_done, dut_out_vld;
  logic [7:0]  gold_out_data, dut_out_data;
  logic        core_rst, flip_stb, camp_done;
  logic [2:0]  flip_set;
  logic [5:0]  flip_idx;
  logic [CW-1:0] cnt_unace, cnt_sdc, cnt_hang;

  seu_campaign_ctrl #(.CNT_W(CW)) u_seu_campaign_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .run_count(run_count),
    .seed(seed), .tgt_sel(tgt_sel), .gold_done(gold_done),
    .gold_out_vld(gold_out_vld), .gold_out_data(gold_out_data),
    .dut_done(dut_done), .dut_out_vld(dut_out_vld),
    .dut_out_data(dut_out_data), .core_rst(core_rst), .flip_stb(flip_stb),
    .flip_set(flip_set), .flip_idx(flip_idx), .cnt_unace(cnt_unace),
    .cnt_sdc(cnt_sdc), .cnt_hang(cnt_hang), .camp_done(camp_done)
  );

  // Behavioural core pair: program ends after L cycles with one output
  logic [15:0] mcyc;
  bit hang_f, corr_f;
  always @(posedge clk) mcyc <= core_rst ? 16'd0 : mcyc + 16'd1;
  assign gold_done     = !core_rst && (mcyc >= 16'(L));
  assign gold_out_vld  = !core_rst && (mcyc == 16'(L));
  assign gold_out_data = 8'hA5;
  assign dut_done      = gold_done && !hang_f;
  assign dut_out_vld   = gold_out_vld;
  assign dut_out_data  = 8'hA5 ^ {7'd0, corr_f};

  int n_tests = 0, n_fail = 0, flips = 0, cyc_ct = 0;
  bit wd_hit = 1'b0;
  bit [15:0] mst;
  bit [2:0]  exp_set;

  function automatic bit [15:0] lstep(bit [15:0] s);
    return (s >> 1) ^ (s[0] ? 16'hB400 : 16'h0000);
  endfunction

  function automatic int grp_w(bit [2:0] s);
    case (s)
      3'd1: return 10;
      3'd2: return 2;
      3'd3: return 5;
      3'd4: return 24;
      default: return 64;
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (core_rst) begin
      hang_f = 1'b0;
      corr_f = 1'b0;
    end
    if (flip_stb) begin
      bit [15:0] a, b;
      a = mst; b = lstep(a); mst = lstep(b);
      flips++;
      chk(int'(mcyc) == int'(a) % L, "R1", "flip cycle", int'(mcyc), int'(a) % L);
      chk(flip_set == exp_set, "R2", "flip group", int'(flip_set), int'(exp_set));
      chk(int'(flip_idx) == int'(b) % grp_w(exp_set), "R2", "flip index",
          int'(flip_idx), int'(b) % grp_w(exp_set));
      if (exp_set == 3'd1 || exp_set == 3'd4) hang_f = 1'b1;
      if (exp_set == 3'd0 || exp_set == 3'd4) corr_f = 1'b1;
    end
  end

  always @(posedge clk) begin
    cyc_ct++;
    if (cyc_ct > 150000) wd_hit = 1'b1;
  end

  task automatic run_camp(bit [2:0] sel, int n, bit [15:0] sd);
    @(negedge clk);
    start = 1'b1; run_count = 16'(n); seed = sd; tgt_sel = sel;
    mst = (sd == 16'd0) ? 16'd1 : sd;
    exp_set = (sel > 3'd4) ? 3'd0 : sel;
    flips = 0;
    @(negedge clk);
    start = 1'b0;
    while (!camp_done && !wd_hit) @(negedge clk);
    chk(flips == n, "R3", "flip pulses", flips, n);
  endtask

  function automatic int sat(int v);
    return (v > 7) ? 7 : v;
  endfunction

  initial begin
    rst_n = 1'b0; start = 1'b0; run_count = '0; seed = '0; tgt_sel = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(core_rst == 1'b1, "R9", "core_rst", int'(core_rst), 1);
    chk(flip_stb == 1'b0, "R9", "flip_stb", int'(flip_stb), 0);
    chk(camp_done == 1'b0, "R9", "camp_done", int'(camp_done), 0);
    chk({cnt_unace, cnt_sdc, cnt_hang} == '0, "R9", "counters",
        int'({cnt_unace, cnt_sdc, cnt_hang}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Table walk: R4 correct, R5 corrupt, R6 hang (with prior mismatch), R1 R2 R10 on each flip
    for (int i = 0; i < 6; i++) begin
      run_camp(VEC[i].sel, int'(VEC[i].runs), VEC[i].seed);
      chk(camp_done == 1'b1, "R8", "camp_done", int'(camp_done), 1);
      chk(int'(cnt_unace) == int'(VEC[i].eu), "R4", "unace", int'(cnt_unace), int'(VEC[i].eu));
      chk(int'(cnt_sdc) == int'(VEC[i].es), "R5", "sdc", int'(cnt_sdc), int'(VEC[i].es));
      chk(int'(cnt_hang) == int'(VEC[i].eh), "R6", "hang", int'(cnt_hang), int'(VEC[i].eh));
      chk(core_rst == 1'b1, "R10", "core_rst after campaign", int'(core_rst), 1);
    end

    // R7 saturation: 10 harmless runs into a 3-bit counter
    run_camp(3'd3, 10, 16'h0F0F);
    chk(int'(cnt_unace) == sat(10), "R7", "saturated unace", int'(cnt_unace), sat(10));
    repeat (5) @(negedge clk);
    chk(int'(cnt_unace) == 7, "R8", "held while done", int'(cnt_unace), 7);

    // R8 zero-length campaign clears counters and finishes after calibration
    run_camp(3'd2, 0, 16'h0042);
    chk(camp_done == 1'b1, "R8", "zero-run done", int'(camp_done), 1);
    chk({cnt_unace, cnt_sdc, cnt_hang} == '0, "R8", "cleared counters",
        int'({cnt_unace, cnt_sdc, cnt_hang}), 0);

    if (wd_hit) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc_ct, 150000);
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule